// File: doc/BRIEF.md
# Multi-Port Banked Scratch RAM

This block is an on-chip word memory that several independent load/store ports share. The storage is split into a power-of-two number of banks. Each bank is a simple array of words with one write path and one read path. Each port supplies a request, a write flag, a word address and write data. The block splits every address into a bank index and an in-bank offset. A build-time list of address bit positions decides which address bits form the bank index. Those positions do not have to be the lowest bits. This lets a designer put a strided or multi-dimensional access pattern onto separate banks.

When the requests in a cycle land on different banks, every port is accepted in that cycle. A port may also be accepted when it shares a bank with another port, as long as one of the two reads and the other writes. When two reads, or two writes, meet on one bank, a round-robin arbiter for that bank and direction accepts one of them. The other ports see ready low and must hold their request until they are accepted. Data is never dropped or merged. Read data comes back one cycle after acceptance, marked by a per-port valid bit.

Top module: `banked_ram`

## Requirements
- R1: The bank index has BANK_BITS bits, so there are 2^BANK_BITS banks. Index bit k equals the address bit whose position is stored in byte field k of the position list. By default the list selects the lowest address bits (bank index = addr[1:0] with two bank bits). The list must hold distinct positions below ADDR_W.
- R2: The address bits that are not in the list form the in-bank offset, taken in ascending bit order. Every one of the 2^ADDR_W addresses therefore reaches its own word, and a value written to one address is read back from that same address.
- R3: When no two requesting ports share both a bank and a direction (read or write), ready equals request for every port in that cycle.
- R4: When two or more reads, or two or more writes, target one bank, exactly one of them sees ready high. Ready is never high without a request. A stalled write leaves memory untouched until it is accepted.
- R5: Each bank keeps separate read and write priority pointers, both at port 0 after reset. After a grant to port p, the search for the next grant starts at port p+1, wrapping around. A port that keeps requesting waits for at most NUM_PORTS-1 grants to others.
- R6: An accepted read presents its word on the port's read data one cycle later, with that port's read-valid high. Read-valid is low in every other cycle.
- R7: A read and a write from different ports to the same bank are both accepted in the same cycle. If they use the same offset, the read returns the value held before the write.
- R8: After reset, with no requests, ready and read-valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_PORTS | Per-port access request |
| we_i | input | NUM_PORTS | Per-port write flag (1 = store, 0 = load) |
| addr_i | input | NUM_PORTS*ADDR_W | Per-port word address, port p in slice p |
| wdata_i | input | NUM_PORTS*DATA_W | Per-port store data |
| ready_o | output | NUM_PORTS | Access accepted this cycle |
| rvalid_o | output | NUM_PORTS | Read data valid (one cycle after an accepted load) |
| rdata_o | output | NUM_PORTS*DATA_W | Per-port load data |

## Verification
The bench targets the non-contiguous bank mapping, using bits 7 and 4. It fills and reads back every address with all four ports at once. A wrong offset packing would alias two words, and a wrong select bit would break the all-ready pattern. A four-way read pile-up on one bank and a two-port alternation check the grant order. A fixed-priority arbiter would serve port 0 every time and starve port 2. A same-cycle read and write of one word must return the older value, and two writes to one word must land in grant order. A bypassing bank or an arbiter that lets both writes through would show the wrong word. A second instance with the default list shows that a low-bit conflict stalls there.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  // Bank-position list: up to 32 byte-wide fields, field k = address bit for bank bit k.
  localparam int SEL_FIELD_W = 8;
  localparam int SEL_MAX     = 32;
  localparam int SEL_LIST_W  = SEL_FIELD_W * SEL_MAX;

  // Default list: field k holds k, i.e. lowest address bits select the bank.
  function automatic logic [SEL_LIST_W-1:0] low_sel_list();
    logic [SEL_LIST_W-1:0] lst;
    lst = '0;
    for (int k = 0; k < SEL_MAX; k++) lst[k*SEL_FIELD_W +: SEL_FIELD_W] = SEL_FIELD_W'(k);
    return lst;
  endfunction

  localparam logic [SEL_LIST_W-1:0] LOW_SEL = low_sel_list();
endpackage

// File: rtl/bmem_addr_split.sv
module bmem_addr_split
  import bmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BANK_BITS = 2,
  parameter logic [SEL_LIST_W-1:0] SEL_POS = LOW_SEL
) (
  input  logic [ADDR_W-1:0]           addr,
  output logic [BANK_BITS-1:0]        bank,
  output logic [ADDR_W-BANK_BITS-1:0] off
);
  localparam int OFF_W = ADDR_W - BANK_BITS;

  function automatic bit is_sel(int b);
    for (int k = 0; k < BANK_BITS; k++)
      if (int'(SEL_POS[k*SEL_FIELD_W +: SEL_FIELD_W]) == b) return 1'b1;
    return 1'b0;
  endfunction

  // Address bit that feeds offset bit j (j-th unselected bit, ascending).
  function automatic int free_pos(int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int b = 0; b < ADDR_W; b++) begin
      if (!is_sel(b)) begin
        if (cnt == j) res = b;
        cnt++;
      end
    end
    return res;
  endfunction

  for (genvar k = 0; k < BANK_BITS; k++) begin : g_bank
    localparam int P = int'(SEL_POS[k*SEL_FIELD_W +: SEL_FIELD_W]);
    assign bank[k] = addr[P];
  end

  for (genvar j = 0; j < OFF_W; j++) begin : g_off
    localparam int P = free_pos(j);
    assign off[j] = addr[P];
  end
endmodule

// File: rtl/bmem_rr_arb.sv
module bmem_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d;
  logic          found;
  int            idx;

  always_comb begin
    gnt   = '0;
    ptr_d = ptr_q;
    found = 1'b0;
    idx   = 0;
    for (int i = 0; i < N; i++) begin
      idx = (int'(ptr_q) + i) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        ptr_d    = PW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (|req) ptr_q <= ptr_d;
  end

  // Checking state: last grant and per-port waiting counters.
  logic [N-1:0] last_gnt_q;
  logic [PW:0]  wait_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_gnt_q <= '0;
      for (int i = 0; i < N; i++) wait_q[i] <= '0;
    end else begin
      last_gnt_q <= gnt;
      for (int i = 0; i < N; i++)
        wait_q[i] <= (req[i] && !gnt[i]) ? wait_q[i] + 1'b1 : '0;
    end
  end

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  assert_some_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_gnt_q[i] && ((req & ~(N'(1) << i)) != '0)) |-> !gnt[i]);
    assert_no_starve_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wait_q[i]) < N);
  end
endmodule

// File: rtl/bmem_bank.sv
module bmem_bank #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Same-edge read sees the pre-write contents.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_data;
    if (rd_en) rd_data     <= mem[rd_off];
  end
endmodule

// File: rtl/banked_ram.sv
module banked_ram
  import bmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BANK_BITS = 2,
  parameter logic [SEL_LIST_W-1:0] SEL_POS = LOW_SEL
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req_i,
  input  logic [NUM_PORTS-1:0]        we_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0] wdata_i,
  output logic [NUM_PORTS-1:0]        ready_o,
  output logic [NUM_PORTS-1:0]        rvalid_o,
  output logic [NUM_PORTS*DATA_W-1:0] rdata_o
);
  localparam int NUM_BANKS = 1 << BANK_BITS;
  localparam int OFF_W     = ADDR_W - BANK_BITS;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  // Address decode per port.
  logic [BANK_BITS-1:0] bank_idx [NUM_PORTS];
  logic [OFF_W-1:0]     offs     [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    bmem_addr_split #(
      .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .SEL_POS(SEL_POS)
    ) u_split (
      .addr(addr_i[p*ADDR_W +: ADDR_W]),
      .bank(bank_idx[p]),
      .off (offs[p])
    );
  end

  // Per-bank, per-direction request vectors.
  logic [NUM_PORTS-1:0] rd_req [NUM_BANKS];
  logic [NUM_PORTS-1:0] wr_req [NUM_BANKS];
  logic [NUM_PORTS-1:0] rd_gnt [NUM_BANKS];
  logic [NUM_PORTS-1:0] wr_gnt [NUM_BANKS];
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        rd_req[b][p] = req_i[p] && !we_i[p] && (bank_idx[p] == BANK_BITS'(b));
        wr_req[b][p] = req_i[p] &&  we_i[p] && (bank_idx[p] == BANK_BITS'(b));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [OFF_W-1:0]  r_off;
    logic [OFF_W-1:0]  w_off;
    logic [DATA_W-1:0] w_dat;

    bmem_rr_arb #(.N(NUM_PORTS)) u_rd_arb (
      .clk(clk), .rst_n(rst_ns), .req(rd_req[b]), .gnt(rd_gnt[b])
    );
    bmem_rr_arb #(.N(NUM_PORTS)) u_wr_arb (
      .clk(clk), .rst_n(rst_ns), .req(wr_req[b]), .gnt(wr_gnt[b])
    );

    // One-hot grants: OR-mux the winner's offset and data.
    always_comb begin
      r_off = '0;
      w_off = '0;
      w_dat = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (rd_gnt[b][p]) r_off = r_off | offs[p];
        if (wr_gnt[b][p]) begin
          w_off = w_off | offs[p];
          w_dat = w_dat | wdata_i[p*DATA_W +: DATA_W];
        end
      end
    end

    bmem_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_bank (
      .clk    (clk),
      .wr_en  (|wr_gnt[b]),
      .wr_off (w_off),
      .wr_data(w_dat),
      .rd_en  (|rd_gnt[b]),
      .rd_off (r_off),
      .rd_data(bank_rd[b])
    );
  end

  // Port handshake and read return.
  logic [NUM_PORTS-1:0] rd_acc;
  logic [NUM_PORTS-1:0] rvalid_q, rvalid_d;
  logic [BANK_BITS-1:0] rbank_q [NUM_PORTS];

  always_comb begin
    ready_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) ready_o = ready_o | rd_gnt[b] | wr_gnt[b];
    rd_acc   = ready_o & req_i & ~we_i;
    rvalid_d = rd_acc;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rvalid_q <= '0;
    else         rvalid_q <= rvalid_d;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_acc[p]) rbank_q[p] <= bank_idx[p];
  end

  assign rvalid_o = rvalid_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rdata
    assign rdata_o[p*DATA_W +: DATA_W] = bank_rd[rbank_q[p]];
  end

  // ---------------- assertions ----------------
  initial begin
    for (int k = 0; k < BANK_BITS; k++) begin
      assert_sel_range_R1: assert (int'(SEL_POS[k*SEL_FIELD_W +: SEL_FIELD_W]) < ADDR_W)
        else $error("bank position %0d out of address range", k);
      for (int j = k + 1; j < BANK_BITS; j++) begin
        assert_sel_unique_R1: assert (SEL_POS[k*SEL_FIELD_W +: SEL_FIELD_W] !=
                                      SEL_POS[j*SEL_FIELD_W +: SEL_FIELD_W])
          else $error("bank positions %0d and %0d repeat", k, j);
      end
    end
  end

  // Pairwise clash detection, independent of the arbiters.
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int q = p + 1; q < NUM_PORTS; q++)
        if (req_i[p] && req_i[q] && (bank_idx[p] == bank_idx[q]) && (we_i[p] == we_i[q]))
          clash = 1'b1;
  end

  assert_parallel_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    !clash |-> (ready_o == req_i));

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    clash |-> (ready_o != req_i));

  assert_ready_req_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (ready_o & ~req_i) == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_rvalid_next_R6: assert property (@(posedge clk) disable iff (!rst_ns)
      (req_i[p] && !we_i[p] && ready_o[p]) |=> rvalid_o[p]);
    assert_rvalid_cause_R6: assert property (@(posedge clk) disable iff (!rst_ns)
      rvalid_o[p] |-> $past(req_i[p] && !we_i[p] && ready_o[p]));
  end
endmodule

// File: tb/test_banked_ram.sv
module test_banked_ram;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk;
  logic rst_n;
  logic [NP-1:0]    req, we;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wdata;
  logic [NP-1:0]    ready, rvalid;
  logic [NP*DW-1:0] rdata;

  logic [NP-1:0]    lreq, lwe;
  logic [NP*AW-1:0] laddr;
  logic [NP*DW-1:0] lwdata;
  logic [NP-1:0]    lready, lrvalid;
  logic [NP*DW-1:0] lrdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Main instance: bank bit 0 = addr[4], bank bit 1 = addr[7].
  banked_ram #(
    .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .BANK_BITS(2), .SEL_POS(256'h0704)
  ) i_banked_ram (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  // Second instance with the default (lowest-bit) mapping.
  banked_ram #(
    .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .BANK_BITS(2)
  ) i_banked_ram_lo (
    .clk(clk), .rst_n(rst_n), .req_i(lreq), .we_i(lwe), .addr_i(laddr), .wdata_i(lwdata),
    .ready_o(lready), .rvalid_o(lrvalid), .rdata_o(lrdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] mk(int bank, int o);
    logic [AW-1:0] a;
    a = '0;
    a[4] = bank[0];
    a[7] = bank[1];
    a[3:0] = o[3:0];
    a[5] = o[4];
    a[6] = o[5];
    return a;
  endfunction

  function automatic logic [DW-1:0] pat(int bank, int o);
    return 32'hA500_0000 | (bank << 8) | o;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req = '0; we = '0; addr = '0; wdata = '0;
    lreq = '0; lwe = '0; laddr = '0; lwdata = '0;
  endtask

  task automatic put(int p, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
    req[p] = 1'b1;
    we[p]  = w;
    addr[p*AW +: AW]  = a;
    wdata[p*DW +: DW] = d;
  endtask

  task automatic do_reset();
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    tick();
    tick();
  endtask

  // R8: quiet outputs after reset.
  task automatic t_reset();
    do_reset();
    #1;
    chk("R8 ready after reset", 32'(ready), 32'h0);
    chk("R8 rvalid after reset", 32'(rvalid), 32'h0);
  endtask

  // R2/R3: four parallel writes per cycle over every address.
  task automatic t_fill();
    int bad;
    bad = 0;
    for (int o = 0; o < 64; o++) begin
      idle();
      for (int p = 0; p < NP; p++) put(p, 1'b1, mk(p, o), pat(p, o));
      #1;
      if (ready !== 4'hF) bad++;
      tick();
    end
    idle();
    chk("R3 all writes ready in every fill cycle", 32'(bad), 32'h0);
  endtask

  // R2/R3/R6: parallel readback of all words.
  task automatic t_readback();
    int bad_rdy;
    int bad_dat;
    bad_rdy = 0;
    bad_dat = 0;
    for (int o = 0; o < 64; o++) begin
      idle();
      for (int p = 0; p < NP; p++) put(p, 1'b0, mk((p + 1) % NP, o), '0);
      #1;
      if (ready !== 4'hF) bad_rdy++;
      tick();
      if (rvalid !== 4'hF) bad_dat++;
      for (int p = 0; p < NP; p++)
        if (rdata[p*DW +: DW] !== pat((p + 1) % NP, o)) bad_dat++;
    end
    chk("R3 all reads ready in every readback cycle", 32'(bad_rdy), 32'h0);
    chk("R2 R6 readback mismatches", 32'(bad_dat), 32'h0);
    chk("R2 sample word bank1 off63", rdata[0 +: DW], pat(1, 63));
    idle();
    tick();
    chk("R6 rvalid low when idle", 32'(rvalid), 32'h0);
  endtask

  // R4/R5: four reads pile onto bank 2; served 0,1,2,3.
  task automatic t_pileup();
    do_reset();
    for (int p = 0; p < NP; p++) put(p, 1'b0, mk(2, 10 + p), '0);
    for (int c = 0; c < NP; c++) begin
      #1;
      chk($sformatf("R4 R5 pileup ready cycle %0d", c), 32'(ready), 32'(1 << c));
      tick();
      chk($sformatf("R6 pileup rvalid cycle %0d", c), 32'(rvalid), 32'(1 << c));
      chk($sformatf("R6 pileup data port %0d", c), rdata[c*DW +: DW], pat(2, 10 + c));
      req[c] = 1'b0;
    end
    idle();
  endtask

  // R5: two persistent readers on bank 1 alternate.
  task automatic t_alternate();
    logic [NP-1:0] exp_r [4];
    exp_r[0] = 4'b0001; exp_r[1] = 4'b0100; exp_r[2] = 4'b0001; exp_r[3] = 4'b0100;
    do_reset();
    put(0, 1'b0, mk(1, 1), '0);
    put(2, 1'b0, mk(1, 2), '0);
    for (int c = 0; c < 4; c++) begin
      #1;
      chk($sformatf("R5 alternate cycle %0d", c), 32'(ready), 32'(exp_r[c]));
      tick();
    end
    idle();
    tick();
  endtask

  // R7: same-cycle read and write on one word returns old data.
  task automatic t_rw_same();
    idle();
    put(0, 1'b0, mk(3, 5), '0);
    put(1, 1'b1, mk(3, 5), 32'h1234_5678);
    #1;
    chk("R7 read and write both ready", 32'(ready), 32'h3);
    tick();
    idle();
    chk("R7 read returns old word", rdata[0 +: DW], pat(3, 5));
    put(0, 1'b0, mk(3, 5), '0);
    tick();
    idle();
    chk("R7 later read returns new word", rdata[0 +: DW], 32'h1234_5678);
  endtask

  // R4/R5: two writes to one word commit in grant order.
  task automatic t_write_clash();
    do_reset();
    put(0, 1'b1, mk(0, 9), 32'hCAFE_0001);
    put(1, 1'b1, mk(0, 9), 32'hCAFE_0002);
    #1;
    chk("R4 write clash first grant", 32'(ready), 32'h1);
    tick();
    req[0] = 1'b0;
    put(2, 1'b0, mk(0, 9), '0);
    #1;
    chk("R4 stalled write and read accepted", 32'(ready), 32'h6);
    tick();
    idle();
    chk("R4 stalled write not yet visible", rdata[2*DW +: DW], 32'hCAFE_0001);
    put(3, 1'b0, mk(0, 9), '0);
    tick();
    idle();
    chk("R5 second write landed last", rdata[3*DW +: DW], 32'hCAFE_0002);
  endtask

  // R1: default list uses the lowest address bits.
  task automatic t_default_map();
    idle();
    for (int p = 0; p < NP; p++) begin
      lreq[p] = 1'b1;
      lwe[p]  = 1'b1;
      laddr[p*AW +: AW]  = (p == 0) ? 8'd4 : AW'(p);
      lwdata[p*DW +: DW] = 32'h5A00_0000 | p;
    end
    #1;
    chk("R1 default map distinct banks", 32'(lready), 32'hF);
    tick();
    idle();
    lreq[0] = 1'b1; laddr[0 +: AW] = 8'd0;
    lreq[1] = 1'b1; laddr[AW +: AW] = 8'd4;
    #1;
    chk("R1 default map addr 0 and 4 clash", 32'(lready), 32'h1);
    tick();
    lreq[0] = 1'b0;
    #1;
    chk("R1 stalled port served next", 32'(lready), 32'h2);
    tick();
    idle();
    chk("R1 R2 default map data", lrdata[DW +: DW], 32'h5A00_0000);
  endtask

  initial begin
    rst_n = 1'b1;
    idle();
    t_reset();
    t_fill();
    t_readback();
    t_pileup();
    t_alternate();
    t_rw_same();
    t_write_clash();
    t_default_map();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule